// File: doc/BRIEF.md
# Reduced-Address Expander with Mirrored High-Part Store

This block sits at the memory end of a compressed address link. The sender keeps a small set of recently used high-order address parts. For each reference it transmits either a short slot index or a reserved miss code, together with the untouched low-order bits. The expander keeps a plain indexed copy of those high parts, one entry per sender slot and in the same positions. It rebuilds the full address by joining the stored high part to the incoming low bits.

After a miss, the same narrow index lines carry two things in order: the slot the sender has chosen to replace, and then the new high part in several small beats. The expander writes that value into the named slot and also uses it for the address that is pending. It does not search for matches and does not choose which slot to replace. All of those decisions arrive in-band from the sender. A flush input drops every stored entry, for example on a context switch.

Top module: `dbx_expander`

## Requirements
- R1: After reset, `addr_valid` and `err_invalid` are low and every slot is invalid, so a first read of any slot reports an error.
- R2: The index field is IDX_W bits wide. The all-ones value is the miss code. The values 0 to 2^IDX_W-2 name slots, and the highest of them is a usable slot.
- R3: In idle, a beat with `rx_valid` high and a valid slot index produces `addr_valid` high on the next cycle, with `addr_out` = {stored high part, `rx_low` of that beat}.
- R4: A fill sequence runs as follows. The miss-code beat supplies the low bits. The next beat names the slot. Then ceil(HIGH_W/IDX_W) payload beats follow, least significant first: payload beat k carries high bits [k*IDX_W +: IDX_W], and the all-ones value is ordinary data here. Cycles with `rx_valid` low are stalls and change nothing.
- R5: The cycle after the last payload beat, `addr_valid` is high and `addr_out` = {new high part, low bits of the miss beat}. The slot then holds that value and is valid, and later hits return it.
- R6: `flush` clears every valid bit. It also abandons any fill in progress, so no write and no `addr_valid` result from it, and the next beat is decoded as a fresh index.
- R7: A read of an invalid slot pulses `err_invalid` high for one cycle on the next cycle, and `addr_valid` stays low.
- R8: A slot beat carrying the miss code pulses `err_invalid` on the next cycle, abandons the fill without any write, and returns to idle.
- R9: `addr_valid` is high only in the cycle that follows a served hit or a completed fill. It stays low during stalls and during the beats of a fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all slots and abandon any fill |
| rx_valid | input | 1 | A beat is present on the index and low lines |
| rx_index | input | IDX_W | Slot index, miss code, slot number or payload beat |
| rx_low | input | LOW_W | Low-order address bits |
| addr_valid | output | 1 | `addr_out` holds a rebuilt address this cycle |
| addr_out | output | HIGH_W+LOW_W | Rebuilt full address |
| err_invalid | output | 1 | Invalid slot was read, or the slot beat was malformed |

## Verification
A stored high part that is corrupted shows up in `addr_out` one cycle after the next hit on that slot. A valid bit that is lost or left set turns into a wrong `err_invalid`/`addr_valid` pair on that same cycle. If the sequencer loses count of beats, the fill completes early or late. That shows on the first wrong `addr_valid` cycle, or in the assembled high bits. Either way, every fault appears no later than the first access that follows it, so each stimulus is checked in the cycle right after the beat that caused it.

// File: rtl/dbx_pkg.sv
// Shared types for the reduced-address expander.
// Assumes nothing beyond the sequencer using these encodings.
package dbx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // decoding hit indices or a miss code
        ST_SLOT = 2'd1,   // next beat names the slot to refill
        ST_PAY  = 2'd2    // collecting payload beats
    } dbx_state_e;
endpackage

// File: rtl/dbx_seq.sv
// Stream sequencer: decodes each beat on the index lines as a hit, a miss
// code, a slot number or a payload beat, and assembles the new high part.
// Assumes HIGH_W > IDX_W (at least two payload beats) and that the sender
// never allocates the miss code as a slot.
module dbx_seq
    import dbx_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int LOW_W  = 8,
    parameter int HIGH_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              rx_valid,
    input  logic [IDX_W-1:0]  rx_index,
    input  logic [LOW_W-1:0]  rx_low,
    output logic              hit_go,
    output logic              fill_done,
    output logic              slot_bad,
    output logic [IDX_W-1:0]  wr_slot,
    output logic [HIGH_W-1:0] wr_data,
    output logic [LOW_W-1:0]  low_hold
);
    localparam int BEATS = (HIGH_W + IDX_W - 1) / IDX_W;
    localparam int PAY_W = BEATS * IDX_W;
    localparam int CNT_W = $clog2(BEATS + 1);
    localparam logic [IDX_W-1:0] MISS_CODE = {IDX_W{1'b1}};

    dbx_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [PAY_W-1:0] pay;
    logic [PAY_W-1:0] pay_next;
    logic [IDX_W-1:0] slot_q;
    logic [LOW_W-1:0] low_q;
    logic             is_miss;
    logic             last_beat;

    // Beat decode and payload assembly (new beat enters at the top, LSB beat ends lowest)
    always_comb begin
        is_miss   = (rx_index == MISS_CODE);
        last_beat = (cnt == CNT_W'(BEATS - 1));
        pay_next  = {rx_index, pay[PAY_W-1:IDX_W]};
        hit_go    = (state == ST_IDLE) && rx_valid && !is_miss;
        slot_bad  = (state == ST_SLOT) && rx_valid && is_miss && !flush;
        fill_done = (state == ST_PAY) && rx_valid && last_beat && !flush;
        wr_data   = pay_next[HIGH_W-1:0];
        wr_slot   = slot_q;
        low_hold  = low_q;
    end

    // Sequencer state, beat counter and captured fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            pay    <= '0;
            slot_q <= '0;
            low_q  <= '0;
        end else if (flush) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (rx_valid) begin
            case (state)
                ST_IDLE: if (is_miss) begin
                    state <= ST_SLOT;
                    low_q <= rx_low;
                end
                ST_SLOT: if (is_miss) begin
                    state <= ST_IDLE;
                end else begin
                    slot_q <= rx_index;
                    cnt    <= '0;
                    state  <= ST_PAY;
                end
                ST_PAY: begin
                    pay <= pay_next;
                    if (last_beat) state <= ST_IDLE;
                    else           cnt   <= cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4
    pay_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAY && rx_valid && !flush && !last_beat)
        |=> (state == ST_PAY && cnt == $past(cnt) + 1'b1));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !flush) |=> ($stable(state) && $stable(cnt)));

    // R6
    flush_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state == ST_IDLE));
endmodule

// File: rtl/dbx_file.sv
// Mirror store: one high-part register and valid bit per sender slot,
// written by index only, read combinationally by index.
// Assumes flush has priority over a write in the same cycle.
module dbx_file #(
    parameter int IDX_W  = 3,
    parameter int HIGH_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_slot,
    input  logic [HIGH_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIGH_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int SLOTS = (1 << IDX_W) - 1;

    logic [HIGH_W-1:0] mem [SLOTS];
    logic [SLOTS-1:0]  vld;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Per-slot storage: cleared by reset or flush, loaded by a matching write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
                vld[g] <= 1'b0;
            end else if (flush) begin
                vld[g] <= 1'b0;
            end else if (wr_en && wr_slot == IDX_W'(g)) begin
                mem[g] <= wr_data;
                vld[g] <= 1'b1;
            end
        end

        // R5
        write_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !flush && wr_slot == IDX_W'(g))
            |=> (vld[g] && mem[g] == $past(wr_data)));
    end

    // Indexed read; the miss code selects nothing
    always_comb begin
        rd_data  = '0;
        rd_valid = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data  = mem[i];
                rd_valid = vld[i];
            end
        end
    end

    // R6
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld == '0));
endmodule

// File: rtl/dbx_expander.sv
// Top: rebuilds full addresses from slot index plus low bits, and refills
// the mirror store from in-band miss sequences. Outputs are registered,
// so every result appears one cycle after the beat that caused it.
// Assumes the sender allocates slots; no search or replacement here.
module dbx_expander #(
    parameter int IDX_W  = 3,
    parameter int LOW_W  = 8,
    parameter int HIGH_W = 12,
    localparam int ADDR_W = HIGH_W + LOW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              rx_valid,
    input  logic [IDX_W-1:0]  rx_index,
    input  logic [LOW_W-1:0]  rx_low,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr_out,
    output logic              err_invalid
);
    logic              hit_go, fill_done, slot_bad, rd_valid;
    logic [IDX_W-1:0]  wr_slot;
    logic [HIGH_W-1:0] wr_data, rd_data;
    logic [LOW_W-1:0]  low_hold;

    dbx_seq #(.IDX_W(IDX_W), .LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .rx_valid(rx_valid), .rx_index(rx_index), .rx_low(rx_low),
        .hit_go(hit_go), .fill_done(fill_done), .slot_bad(slot_bad),
        .wr_slot(wr_slot), .wr_data(wr_data), .low_hold(low_hold)
    );

    dbx_file #(.IDX_W(IDX_W), .HIGH_W(HIGH_W)) u_file (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(fill_done), .wr_slot(wr_slot), .wr_data(wr_data),
        .rd_idx(rx_index), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Output register: served hit, completed fill, or error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid  <= 1'b0;
            err_invalid <= 1'b0;
            addr_out    <= '0;
        end else begin
            addr_valid  <= (hit_go && rd_valid) || fill_done;
            err_invalid <= (hit_go && !rd_valid) || slot_bad;
            if (hit_go && rd_valid)
                addr_out <= {rd_data, rx_low};
            else if (fill_done)
                addr_out <= {wr_data, low_hold};
        end
    end

    // R7
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_invalid |-> !addr_valid);

    // R3
    hit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_go && rd_valid) |=> (addr_valid && addr_out[LOW_W-1:0] == $past(rx_low)));

    // R8
    slot_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_bad |=> (err_invalid && !addr_valid));
endmodule

// File: tb/dbx_expander_test.sv
module dbx_expander_test;
    localparam int IDX_W  = 3;
    localparam int LOW_W  = 8;
    localparam int HIGH_W = 12;
    localparam int ADDR_W = HIGH_W + LOW_W;
    localparam int BEATS  = (HIGH_W + IDX_W - 1) / IDX_W;
    localparam logic [IDX_W-1:0] MISS = '1;

    typedef struct packed {
        logic              v;
        logic [IDX_W-1:0]  idx;
        logic [LOW_W-1:0]  low;
        logic              av;
        logic              err;
        logic [ADDR_W-1:0] addr;
    } vec_t;

    // Fill slot 3 with 0xABC (beats 4,7,2,5) with a stall, then hit it
    localparam vec_t TBL [12] = '{
        '{1'b1, 3'd2, 8'h11, 1'b0, 1'b1, 20'h0},      // R1 R7 empty slot
        '{1'b1, 3'd7, 8'h5A, 1'b0, 1'b0, 20'h0},      // R2 miss code
        '{1'b1, 3'd3, 8'h00, 1'b0, 1'b0, 20'h0},      // R4 slot beat
        '{1'b1, 3'd4, 8'h00, 1'b0, 1'b0, 20'h0},      // R4 payload 0
        '{1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 20'h0},      // R4 stall
        '{1'b1, 3'd7, 8'h00, 1'b0, 1'b0, 20'h0},      // R4 all-ones is data
        '{1'b1, 3'd2, 8'h00, 1'b0, 1'b0, 20'h0},      // R9 payload 2
        '{1'b1, 3'd5, 8'h00, 1'b1, 1'b0, 20'hABC5A},  // R5 fill result
        '{1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 20'h0},      // R9 idle
        '{1'b1, 3'd3, 8'h33, 1'b1, 1'b0, 20'hABC33},  // R3 hit
        '{1'b1, 3'd3, 8'hFF, 1'b1, 1'b0, 20'hABCFF},  // R3 back-to-back
        '{1'b1, 3'd0, 8'h01, 1'b0, 1'b1, 20'h0}       // R7 other slot empty
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic              rx_valid = 1'b0;
    logic [IDX_W-1:0]  rx_index = '0;
    logic [LOW_W-1:0]  rx_low = '0;
    logic              addr_valid, err_invalid;
    logic [ADDR_W-1:0] addr_out;
    int                n_chk = 0;
    int                n_fail = 0;
    bit                done = 1'b0;

    always #2.5 clk = ~clk;

    dbx_expander #(.IDX_W(IDX_W), .LOW_W(LOW_W), .HIGH_W(HIGH_W)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .rx_valid(rx_valid),
        .rx_index(rx_index), .rx_low(rx_low), .addr_valid(addr_valid),
        .addr_out(addr_out), .err_invalid(err_invalid)
    );

    task automatic chk(input string req, input logic av_e, input logic err_e,
                       input logic [ADDR_W-1:0] a_e);
        n_chk++;
        if (addr_valid !== av_e || err_invalid !== err_e ||
            (av_e && addr_out !== a_e)) begin
            n_fail++;
            $display("FAIL %s: av=%b err=%b addr=%h, expected av=%b err=%b addr=%h",
                     req, addr_valid, err_invalid, addr_out, av_e, err_e, a_e);
        end
    endtask

    // Drive one beat at a falling edge; outputs are sampled one cycle later
    task automatic beat(input logic v, input logic [IDX_W-1:0] idx,
                        input logic [LOW_W-1:0] low, input logic fl);
        rx_valid = v; rx_index = idx; rx_low = low; flush = fl;
        @(negedge clk);
        rx_valid = 1'b0; flush = 1'b0;
    endtask

    // Full miss sequence; payload least significant first
    task automatic fill(input logic [IDX_W-1:0] slot, input logic [HIGH_W-1:0] hi,
                        input logic [LOW_W-1:0] low, input string req);
        logic [BEATS*IDX_W-1:0] p;
        p = (BEATS*IDX_W)'(hi);
        beat(1'b1, MISS, low, 1'b0);
        chk("R9 miss beat", 1'b0, 1'b0, '0);
        beat(1'b1, slot, '0, 1'b0);
        for (int k = 0; k < BEATS; k++) begin
            beat(1'b1, p[k*IDX_W +: IDX_W], '0, 1'b0);
            if (k < BEATS - 1) chk("R9 payload beat", 1'b0, 1'b0, '0);
        end
        chk(req, 1'b1, 1'b0, {hi, low});
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 in reset", 1'b0, 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 1'b0, 1'b0, '0);

        for (int i = 0; i < 12; i++) begin
            beat(TBL[i].v, TBL[i].idx, TBL[i].low, 1'b0);
            chk($sformatf("table row %0d (R3 R4 R5 R7 R9)", i), TBL[i].av, TBL[i].err, TBL[i].addr);
        end

        // R6: flush invalidates slot 3
        beat(1'b0, '0, '0, 1'b1);
        chk("R6 flush cycle", 1'b0, 1'b0, '0);
        beat(1'b1, 3'd3, 8'h44, 1'b0);
        chk("R6 slot 3 invalid after flush", 1'b0, 1'b1, '0);

        // R2: highest slot with all-ones payload
        fill(3'd6, 12'hFFF, 8'h80, "R2 R5 fill top slot");
        beat(1'b1, 3'd6, 8'h01, 1'b0);
        chk("R2 hit top slot", 1'b1, 1'b0, 20'hFFF01);

        // R8: malformed slot beat
        beat(1'b1, MISS, 8'h10, 1'b0);
        beat(1'b1, MISS, 8'h00, 1'b0);
        chk("R8 miss code as slot", 1'b0, 1'b1, '0);
        beat(1'b1, 3'd6, 8'h22, 1'b0);
        chk("R8 idle again, slot 6 intact", 1'b1, 1'b0, 20'hFFF22);

        // R6: flush in the middle of a fill
        beat(1'b1, MISS, 8'h77, 1'b0);
        beat(1'b1, 3'd1, 8'h00, 1'b0);
        beat(1'b1, 3'd5, 8'h00, 1'b0);
        beat(1'b1, 3'd1, 8'h00, 1'b1);
        chk("R6 aborted fill no result", 1'b0, 1'b0, '0);
        beat(1'b1, 3'd1, 8'h09, 1'b0);
        chk("R6 aborted slot not written", 1'b0, 1'b1, '0);
        beat(1'b1, 3'd6, 8'h09, 1'b0);
        chk("R6 slot 6 cleared", 1'b0, 1'b1, '0);

        // R5: refill after flush, then hit with new low bits
        fill(3'd1, 12'h5A3, 8'hC4, "R5 refill slot 1");
        beat(1'b0, '0, '0, 1'b0);
        chk("R9 no pulse when idle", 1'b0, 1'b0, '0);
        beat(1'b1, 3'd1, 8'h3E, 1'b0);
        chk("R3 hit refilled slot", 1'b1, 1'b0, 20'h5A33E);

        finish_up();
    end
endmodule